// File: doc/BRIEF.md
# Polyphase Horizontal Line Scaler

This block resamples one video line at a time along the horizontal axis. Pixels enter on a valid/ready stream that carries start-of-line and end-of-line flags. The block first stores the whole line in an internal line store. It then produces a programmed number of output pixels. For each output pixel, a phase accumulator advances by a fixed-point step that holds an integer part and a 24-bit fraction. The integer part of the accumulator names the centre source pixel. The upper fraction bits pick one row of four filter weights from a writable table.

The weight table holds 33 rows of four signed 11-bit taps. Phases above the midpoint reuse a lower row with its taps reversed. A control write sets the table pointer. Each data write after it stores two taps and advances the pointer. When horizontal scaling is switched off, the stream passes straight through.

Top module: `hscale_top`

## Requirements
- R1: When `hsc_en_i` is low, the output data, valid, start and end flags equal the input ones in the same cycle, and `in_ready_o` equals `out_ready_i`.
- R2: With scaling on, the block accepts pixels (`in_ready_o` high) until a beat with `in_eol_i` is taken. A beat with `in_sol_i` stores its pixel at position 0. After the end beat, `in_ready_o` stays low until the last output pixel of the line has been issued.
- R3: At most `MAX_W` pixels are stored per line; extra beats are accepted and discarded, and the line width becomes `MAX_W`.
- R4: Each stored line yields exactly `out_width_i` output pixels; the first carries `out_sol_o`, the last carries `out_eol_o`.
- R5: Output k uses position k·step, where step = {`step_int_i`, `step_frac_i`} (24 fraction bits). The phase is fraction bits [23:18]. A phase p ≤ 32 uses row p as taps (t0,t1,t2,t3). A phase p > 32 uses row 64−p with its taps reversed (t3,t2,t1,t0).
- R6: The four taps weight source pixels at integer position −1, +0, +1 and +2 in that order. An index below 0 reads pixel 0, and an index past the end reads the last stored pixel.
- R7: The weighted sum gets 256 added and is then shifted arithmetically right by 9. The result is clamped to 0..1023.
- R8: A write with `coef_ctrl_i` high sets the table pointer to row `coef_wdata_i[5:0]`, half 0. Each data write stores `coef_wdata_i[10:0]` and `[21:11]` as taps 0 and 1 (half 0) or taps 2 and 3 (half 1), then advances half, then row.
- R9: Data writes made while the pointer is at row 33 or above change nothing.
- R10: While an output pixel is valid and `out_ready_i` is low, the pixel and its flags hold.
- R11: After reset, `out_valid_o` is low, `in_ready_o` is high with scaling on, and all taps are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsc_en_i | input | 1 | Scaling on (1) or pass-through (0) |
| step_int_i | input | 8 | Integer part of the phase step |
| step_frac_i | input | 24 | Fraction part of the phase step |
| out_width_i | input | 7 | Output pixels per line |
| coef_we_i | input | 1 | Table write strobe |
| coef_ctrl_i | input | 1 | Write is a pointer/control word |
| coef_wdata_i | input | 22 | Tap pair or start row |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted |
| in_pix_i | input | 10 | Input pixel |
| in_sol_i | input | 1 | First pixel of line |
| in_eol_i | input | 1 | Last pixel of line |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_pix_o | output | 10 | Output pixel |
| out_sol_o | output | 1 | First output of line |
| out_eol_o | output | 1 | Last output of line |

## Verification
A table write takes effect at the next rising edge. The first scaled pixel of a line becomes valid one cycle after the edge that takes the end-of-line beat. Further pixels follow one per cycle while `out_ready_i` is high. Pass-through results appear in the same cycle. The bench drives inputs and samples outputs at the falling edge. It counts an output only on a cycle where valid and ready are both high, so a stall cannot shift the expected sequence. Where a pixel is held under backpressure, the bench compares it with the value seen one cycle earlier.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int PIX_W   = 10;
  localparam int COEF_W  = 11;
  localparam int TAPS    = 4;
  localparam int FRAC_W  = 24;
  localparam int PH_W    = 6;
  localparam int ROWS    = 2 ** (PH_W - 1) + 1;
  localparam int NORM_SH = 9;
  localparam int STEP_IW = 8;
  localparam int POS_W   = 16;
  localparam int MAX_W   = 64;
  typedef enum logic {ST_LOAD, ST_EMIT} hs_state_e;
endpackage

// File: rtl/hs_coef_tab.sv
module hs_coef_tab #(
  parameter int ROWS   = hs_pkg::ROWS,
  parameter int COEF_W = hs_pkg::COEF_W,
  parameter int PH_W   = hs_pkg::PH_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic                  ctrl_i,
  input  logic [2*COEF_W-1:0]   wdata_i,
  input  logic [PH_W-1:0]       phase_i,
  output logic [4*COEF_W-1:0]   taps_o
);
  localparam int RW   = PH_W;
  localparam int FULL = 2 ** PH_W;
  localparam int HALF = FULL / 2;

  logic [2*COEF_W-1:0] mem [ROWS][2];
  logic [RW-1:0]       row_q;
  logic                half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      half_q <= 1'b0;
      for (int r = 0; r < ROWS; r++) begin
        mem[r][0] <= '0;
        mem[r][1] <= '0;
      end
    end else if (we_i) begin
      if (ctrl_i) begin
        row_q  <= wdata_i[RW-1:0];
        half_q <= 1'b0;
      end else if (32'(row_q) < ROWS) begin
        mem[row_q][half_q] <= wdata_i;
        half_q <= ~half_q;
        if (half_q) row_q <= row_q + RW'(1);
      end
    end
  end

  logic              mirror;
  logic [PH_W:0]     rsel;
  logic [COEF_W-1:0] t [4];

  always_comb begin
    mirror = phase_i > PH_W'(HALF);
    rsel   = mirror ? (PH_W+1)'(FULL) - {1'b0, phase_i} : {1'b0, phase_i};
    t[0]   = mem[rsel[RW-1:0]][0][COEF_W-1:0];
    t[1]   = mem[rsel[RW-1:0]][0][2*COEF_W-1:COEF_W];
    t[2]   = mem[rsel[RW-1:0]][1][COEF_W-1:0];
    t[3]   = mem[rsel[RW-1:0]][1][2*COEF_W-1:COEF_W];
  end

  for (genvar g = 0; g < 4; g++) begin : g_tap
    assign taps_o[g*COEF_W +: COEF_W] = mirror ? t[3-g] : t[g];
  end

  // R9
  past_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !ctrl_i && 32'(row_q) >= ROWS) |=> ($stable(row_q) && !half_q));
endmodule

// File: rtl/hs_line_buf.sv
module hs_line_buf #(
  parameter int MAX_W = hs_pkg::MAX_W,
  parameter int PIX_W = hs_pkg::PIX_W,
  parameter int POS_W = hs_pkg::POS_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic                         wr_sol_i,
  input  logic                         wr_eol_i,
  input  logic [PIX_W-1:0]             wr_pix_i,
  input  logic [POS_W-1:0]             pos_i,
  output logic [$clog2(MAX_W+1)-1:0]   width_o,
  output logic [4*PIX_W-1:0]           win_o
);
  localparam int LW = $clog2(MAX_W + 1);
  localparam int AW = $clog2(MAX_W);
  localparam int SW = POS_W + 2;

  logic [PIX_W-1:0] mem [MAX_W];
  logic [LW-1:0]    wptr_q, width_q, widx, nptr;
  logic             room;

  always_comb begin
    widx = wr_sol_i ? '0 : wptr_q;
    room = 32'(widx) < MAX_W;
    nptr = room ? widx + LW'(1) : widx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      width_q <= LW'(1);
    end else if (wr_en_i) begin
      wptr_q <= wr_eol_i ? '0 : nptr;
      if (wr_eol_i) width_q <= nptr;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && room) mem[widx[AW-1:0]] <= wr_pix_i;
  end

  assign width_o = width_q;

  logic signed [SW-1:0] wid_s;
  assign wid_s = $signed({{(SW-LW){1'b0}}, width_q});

  for (genvar g = 0; g < 4; g++) begin : g_win
    logic signed [SW-1:0] s, sel;
    always_comb begin
      s = $signed({2'b00, pos_i}) + SW'(g) - SW'(1);
      if (s < 0)           sel = '0;
      else if (s >= wid_s) sel = wid_s - SW'(1);
      else                 sel = s;
    end
    assign win_o[g*PIX_W +: PIX_W] = mem[sel[AW-1:0]];
  end

  // R3
  width_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_eol_i) |=> (32'(width_o) <= MAX_W && width_o != '0));
endmodule

// File: rtl/hs_fir.sv
module hs_fir #(
  parameter int PIX_W   = hs_pkg::PIX_W,
  parameter int COEF_W  = hs_pkg::COEF_W,
  parameter int NORM_SH = hs_pkg::NORM_SH
) (
  input  logic [4*COEF_W-1:0] taps_i,
  input  logic [4*PIX_W-1:0]  win_i,
  output logic [PIX_W-1:0]    pix_o
);
  localparam int ACC_W = COEF_W + PIX_W + 3;
  localparam int RND   = 1 << (NORM_SH - 1);
  localparam int PMAX  = (1 << PIX_W) - 1;

  logic signed [ACC_W-1:0]  sum, shd;
  logic signed [COEF_W-1:0] c;
  logic signed [PIX_W:0]    x;

  always_comb begin
    sum = '0;
    c   = '0;
    x   = '0;
    for (int t = 0; t < 4; t++) begin
      c   = $signed(taps_i[t*COEF_W +: COEF_W]);
      x   = $signed({1'b0, win_i[t*PIX_W +: PIX_W]});
      sum = sum + ACC_W'(c) * ACC_W'(x);
    end
    shd = (sum + ACC_W'(RND)) >>> NORM_SH;
    if (shd < 0)                  pix_o = '0;
    else if (shd > ACC_W'(PMAX))  pix_o = PIX_W'(PMAX);
    else                          pix_o = shd[PIX_W-1:0];
  end
endmodule

// File: rtl/hscale_top.sv
module hscale_top
  import hs_pkg::*;
#(
  parameter int MAX_W_P = hs_pkg::MAX_W,
  parameter int LW      = $clog2(MAX_W_P + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hsc_en_i,
  input  logic [STEP_IW-1:0]    step_int_i,
  input  logic [FRAC_W-1:0]     step_frac_i,
  input  logic [LW-1:0]         out_width_i,
  input  logic                  coef_we_i,
  input  logic                  coef_ctrl_i,
  input  logic [2*COEF_W-1:0]   coef_wdata_i,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [PIX_W-1:0]      in_pix_i,
  input  logic                  in_sol_i,
  input  logic                  in_eol_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [PIX_W-1:0]      out_pix_o,
  output logic                  out_sol_o,
  output logic                  out_eol_o
);
  localparam int AC_W = POS_W + FRAC_W;

  hs_state_e         state_q;
  logic [AC_W-1:0]   acc_q, step;
  logic [LW-1:0]     cnt_q, lw_unused;
  logic              oval_q, osol_q, oeol_q;
  logic [PIX_W-1:0]  opix_q, fir_pix;
  logic [4*COEF_W-1:0] taps;
  logic [4*PIX_W-1:0]  win;
  logic              cap_fire, adv, last;

  assign step     = {{(POS_W-STEP_IW){1'b0}}, step_int_i, step_frac_i};
  assign cap_fire = hsc_en_i && state_q == ST_LOAD && in_valid_i;
  assign adv      = state_q == ST_EMIT && (!oval_q || out_ready_i);
  assign last     = cnt_q == out_width_i - LW'(1);

  hs_coef_tab u_tab (
    .clk_i, .rst_ni,
    .we_i    (coef_we_i),
    .ctrl_i  (coef_ctrl_i),
    .wdata_i (coef_wdata_i),
    .phase_i (acc_q[FRAC_W-1 -: PH_W]),
    .taps_o  (taps)
  );

  hs_line_buf #(.MAX_W(MAX_W_P)) u_lb (
    .clk_i, .rst_ni,
    .wr_en_i  (cap_fire),
    .wr_sol_i (in_sol_i),
    .wr_eol_i (in_eol_i),
    .wr_pix_i (in_pix_i),
    .pos_i    (acc_q[AC_W-1:FRAC_W]),
    .width_o  (lw_unused),
    .win_o    (win)
  );

  hs_fir u_fir (.taps_i(taps), .win_i(win), .pix_o(fir_pix));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      acc_q   <= '0;
      cnt_q   <= '0;
      oval_q  <= 1'b0;
      osol_q  <= 1'b0;
      oeol_q  <= 1'b0;
      opix_q  <= '0;
    end else begin
      if (cap_fire && in_eol_i) begin
        acc_q <= '0;
        cnt_q <= '0;
        if (out_width_i != '0) state_q <= ST_EMIT;
      end
      if (adv) begin
        opix_q <= fir_pix;
        osol_q <= cnt_q == '0;
        oeol_q <= last;
        oval_q <= 1'b1;
        acc_q  <= acc_q + step;
        cnt_q  <= cnt_q + LW'(1);
        if (last) state_q <= ST_LOAD;
      end else if (out_ready_i) begin
        oval_q <= 1'b0;
      end
    end
  end

  assign in_ready_o  = hsc_en_i ? state_q == ST_LOAD : out_ready_i;
  assign out_valid_o = hsc_en_i ? oval_q : in_valid_i;
  assign out_pix_o   = hsc_en_i ? opix_q : in_pix_i;
  assign out_sol_o   = hsc_en_i ? osol_q : in_sol_i;
  assign out_eol_o   = hsc_en_i ? oeol_q : in_eol_i;

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oval_q && !out_ready_i) |=> (oval_q && $stable(opix_q) && $stable(oeol_q)));

  // R2
  cap_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_fire && in_eol_i && out_width_i != '0) |=> state_q == ST_EMIT);

  // R4
  line_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oval_q && out_ready_i && oeol_q) |=> !oval_q);
endmodule

// File: tb/sim_hscale_top.sv
module sim_hscale_top;
  localparam int MW = 64;
  localparam int NV = 6;
  // src width, dst width, pattern, stall
  localparam int VEC [NV][4] = '{
    '{32, 32, 0, 0}, '{32, 20, 1, 0}, '{20, 32, 2, 1},
    '{40, 13, 1, 0}, '{16, 48, 1, 1}, '{64, 64, 2, 0}};

  logic clk = 0, rst_n = 0;
  logic hsc_en = 1;
  logic [7:0] step_int = 0;
  logic [23:0] step_frac = 0;
  logic [6:0] out_w = 0;
  logic cwe = 0, cctrl = 0;
  logic [21:0] cdata = 0;
  logic in_valid = 0, in_sol = 0, in_eol = 0, out_ready = 1;
  logic [9:0] in_pix = 0;
  logic in_ready, out_valid, out_sol, out_eol;
  logic [9:0] out_pix;

  int tests = 0, fails = 0;
  int line_a [80];
  int coef [33][4];
  longint step64;
  bit done = 0;

  always #10 clk = ~clk;

  hscale_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .hsc_en_i(hsc_en), .step_int_i(step_int),
    .step_frac_i(step_frac), .out_width_i(out_w), .coef_we_i(cwe),
    .coef_ctrl_i(cctrl), .coef_wdata_i(cdata), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .in_pix_i(in_pix), .in_sol_i(in_sol),
    .in_eol_i(in_eol), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_pix_o(out_pix), .out_sol_o(out_sol), .out_eol_o(out_eol));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pix(int k, int w);
    longint pos = k * step64;
    int ip = int'(pos >>> 24);
    int ph = int'((pos >>> 18) & 63);
    int r = ph > 32 ? 64 - ph : ph;
    int sum = 0, v;
    for (int t = 0; t < 4; t++) begin
      int s = ip + t - 1;
      int c = ph > 32 ? coef[r][3-t] : coef[r][t];
      if (s < 0) s = 0;
      if (s > w - 1) s = w - 1;
      sum += c * line_a[s];
    end
    v = (sum + 256) >>> 9;
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  task automatic cw(input bit ctl, input int d);
    cwe = 1; cctrl = ctl; cdata = 22'(d);
    @(negedge clk);
    cwe = 0; cctrl = 0;
  endtask

  task automatic write_row(input int r);
    cw(0, ((coef[r][1] & 2047) << 11) | (coef[r][0] & 2047));
    cw(0, ((coef[r][3] & 2047) << 11) | (coef[r][2] & 2047));
  endtask

  task automatic set_step(input int src, input int dst);
    step_int  = 8'(src / dst);
    step_frac = 24'((((src << 12) / dst) << 12));
    step64    = (longint'(step_int) << 24) | longint'(step_frac);
    out_w     = 7'(dst);
  endtask

  task automatic fill(input int w, input int pat);
    for (int i = 0; i < w; i++)
      case (pat)
        0: line_a[i] = (i * 13) & 1023;
        1: line_a[i] = i < w / 2 ? 0 : 1023;
        default: line_a[i] = (i * i * 7 + 3) & 1023;
      endcase
  endtask

  task automatic send_line(input int w);
    for (int i = 0; i < w; i++) begin
      int g = 0;
      while (!in_ready && g < 500) begin @(negedge clk); g++; end
      in_valid = 1; in_pix = 10'(line_a[i]);
      in_sol = i == 0; in_eol = i == w - 1;
      @(negedge clk);
    end
    in_valid = 0; in_sol = 0; in_eol = 0;
  endtask

  // R4 R5 R6 R7 R10: one line, all outputs compared
  task automatic collect(input int ow, input int wcap, input bit stall, input string tag);
    int k = 0, g = 0, held = -1;
    while (k < ow && g < 5000) begin
      out_ready = stall ? (g % 3 != 0) : 1'b1;
      #1;
      if (held >= 0) begin
        chk(out_valid && out_pix == 10'(held), "R10 hold", out_pix, held);
        held = -1;
      end
      if (out_valid && out_ready) begin
        int e = exp_pix(k, wcap);
        chk(out_pix == 10'(e), tag, out_pix, e);
        chk(out_sol == (k == 0), "R4 sol", out_sol, k == 0);
        chk(out_eol == (k == ow - 1), "R4 eol", out_eol, k == ow - 1);
        k++;
      end else if (out_valid) held = out_pix;
      @(negedge clk);
      g++;
    end
    out_ready = 1;
    chk(k == ow, "R4 count", k, ow);
  endtask

  task automatic run(input int src, input int dst, input int pat, input bit stall, input string tag);
    set_step(src, dst);
    fill(src, pat);
    send_line(src);
    chk(!in_ready, "R2 busy", in_ready, 0);
    collect(dst, src > MW ? MW : src, stall, tag);
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 33; r++) for (int t = 0; t < 4; t++) coef[r][t] = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!out_valid, "R11 valid", out_valid, 0);
    chk(in_ready, "R11 ready", in_ready, 1);
    rst_n = 1;
    @(negedge clk);
    // R11 zero table gives all-zero output
    run(8, 8, 0, 0, "R11 zero table");

    // R8 load table from row 0
    for (int p = 0; p < 33; p++) begin
      coef[p][0] = -p; coef[p][1] = 511 - 8 * p;
      coef[p][2] = 10 * p + 1; coef[p][3] = -p;
    end
    cw(1, 0);
    for (int r = 0; r < 33; r++) write_row(r);

    for (int v = 0; v < NV; v++)
      run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3] != 0, "R5 R6 R7 vector");

    // R9 write past row 32 ignored
    cw(0, 22'h3FFFFF);
    cw(0, 22'h2AAAAA);
    run(20, 32, 2, 0, "R9 past end");

    // R8 control word selects start row
    coef[0][0] = 0; coef[0][1] = 256; coef[0][2] = 256; coef[0][3] = 0;
    cw(1, 0);
    write_row(0);
    coef[32][0] = -60; coef[32][1] = 320; coef[32][2] = 300; coef[32][3] = -48;
    cw(1, 32);
    write_row(32);
    run(32, 32, 0, 0, "R8 row0");
    run(16, 32, 1, 0, "R8 row32");

    // R3 overflow: 70 beats, width capped at 64
    run(70, 64, 0, 0, "R3 cap");

    // R1 bypass
    hsc_en = 0;
    for (int i = 0; i < 6; i++) begin
      in_valid = i[0]; in_pix = 10'(100 + 37 * i);
      in_sol = i == 0; in_eol = i == 5; out_ready = i != 2;
      #1;
      chk(out_pix == in_pix && out_valid == in_valid, "R1 data", out_pix, in_pix);
      chk(out_sol == in_sol && out_eol == in_eol, "R1 flags", out_eol, in_eol);
      chk(in_ready == out_ready, "R1 ready", in_ready, out_ready);
      @(negedge clk);
    end
    in_valid = 0; in_sol = 0; in_eol = 0; out_ready = 1;
    hsc_en = 1;
    @(negedge clk);
    run(24, 24, 2, 1, "R2 after bypass");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule